// File: doc/BRIEF.md
# Second-Order Cascaded Fractional Modulus Sequencer

This block steers the modulus control of a fractional-N feedback divider. It runs once per reference clock. Each cycle it emits a 2-bit code that tells the divider to count by N-1, N, N+1 or N+2 for that reference period. Two first-order accumulators are cascaded. The second one integrates the residue left in the first. The carry of the second stage is differentiated against its own value from one cycle earlier and added to the first-stage carry. This gives an integer offset between -1 and +2. The offsets move the quantisation error to high frequencies, and their long-run average equals the fractional word divided by 2^FRAC_W.

A pseudo-random dither bit can be added to the least significant bit of the first accumulator's input. This breaks up the idle tones that short repeating patterns produce. The dither source is a 16-bit LFSR that loads its seed in the first clock after reset. The block outputs both the divider code and the signed offset that the code stands for.

Top module: `mash11_mod_seq`

## Requirements
- R1: The modulus code encodes the offset as follows: 2'b11 for -1 (N-1), 2'b00 for 0 (N), 2'b01 for +1 (N+1) and 2'b10 for +2 (N+2).
- R2: The offset is registered. It takes the value computed from the inputs at each rising edge: first-stage carry plus second-stage carry, minus the second-stage carry of the previous edge. It always lies in the range -1 to +2.
- R3: Each edge, the first accumulator adds the fractional word plus the dither bit, and the second accumulator adds the updated residue of the first. Both accumulators wrap modulo 2^FRAC_W, and a wrap produces that stage's carry. This holds up to the extreme words 1 and 2^FRAC_W-1.
- R4: With dither off and a constant word F applied from reset, the sum of the offsets over 1024 cycles is within 1 of F*1024/2^FRAC_W. This is checked for F = 2/8 and F = 5/8 of full scale.
- R5: With a zero fractional word and dither off after reset, the code stays at 2'b00 on every cycle.
- R6: While rst_ni is low, the accumulators, the carry delay and the LFSR are cleared, and the outputs read offset 0 and code 2'b00.
- R7: In the first edge after reset, the LFSR loads seed_i, or 16'h0001 if the seed is zero, and the dither bit is 0. On each later edge it shifts left and feeds in bit15^bit13^bit12^bit10 at bit 0. The dither bit equals LFSR bit 0 when dith_en_i is high, and 0 when dith_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference-rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frac_i | input | FRAC_W | Fractional word, in units of 1/2^FRAC_W |
| dith_en_i | input | 1 | Enables the LSB dither |
| seed_i | input | 16 | LFSR seed, loaded after reset |
| mod_code_o | output | 2 | Divider modulus code |
| offset_o | output | 3 | Signed offset from N (-1 to +2) |

## Verification
The assertions assume that rst_ni is released away from a clock edge. They also assume that frac_i, dith_en_i and seed_i are stable around each rising edge; the bench meets this by changing the inputs only on falling edges. The carry-delay assertion is held off until one edge after reset has been seen, so it never compares against a value captured while the block was in reset. The stimulus covers the zero word, both extreme words, the two mean-value words, a zero seed and a word that changes every cycle. In each case the bench follows the registered timing of the offset, so the checked output is the one produced by the edge just before.

// File: rtl/mash_seq_pkg.sv
package mash_seq_pkg;
  typedef enum logic [1:0] {
    MOD_N  = 2'b00,
    MOD_P1 = 2'b01,
    MOD_P2 = 2'b10,
    MOD_M1 = 2'b11
  } mod_code_e;

  function automatic mod_code_e off_to_code(input logic signed [2:0] off);
    case (off)
      3'sb111: return MOD_M1;
      3'sb001: return MOD_P1;
      3'sb010: return MOD_P2;
      default: return MOD_N;
    endcase
  endfunction
endpackage

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  input  logic         cin_i,
  output logic         carry_o,
  output logic [W-1:0] res_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, in_i} + {{W{1'b0}}, cin_i};
  assign carry_o = sum[W];
  assign res_o   = sum[W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= res_o;
  end

  // R3
  wrap_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> (res_o <= acc_q));
  // R3
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_o |-> (res_o >= acc_q));
endmodule

// File: rtl/mash_dither_lfsr.sv
module mash_dither_lfsr #(
  parameter int                 LFSR_W   = 16,
  parameter logic [LFSR_W-1:0]  TAPS     = 16'hB400,
  parameter logic [LFSR_W-1:0]  FALLBACK = 16'h0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic              en_i,
  output logic              bit_o
);
  logic              seeded_q;
  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] lfsr_d;
  logic              fb;

  assign fb    = ^(lfsr_q & TAPS);
  assign bit_o = en_i & seeded_q & lfsr_q[0];

  always_comb begin
    if (!seeded_q) lfsr_d = (seed_i == '0) ? FALLBACK : seed_i;
    else           lfsr_d = {lfsr_q[LFSR_W-2:0], fb};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seeded_q <= 1'b0;
      lfsr_q   <= '0;
    end else begin
      seeded_q <= 1'b1;
      lfsr_q   <= lfsr_d;
    end
  end

  // R7
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seeded_q |-> (lfsr_q != '0));
  // R7
  seed_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seeded_q |=> seeded_q);
endmodule

// File: rtl/mash_out_comb.sv
module mash_out_comb
  import mash_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              c1_i,
  input  logic              c2_i,
  output logic signed [2:0] offset_o,
  output logic [1:0]        code_o
);
  logic              c2_d_q;
  logic signed [2:0] off_d;
  logic signed [2:0] off_q;
  mod_code_e         code_q;

  assign off_d = $signed({2'b00, c1_i}) + $signed({2'b00, c2_i}) - $signed({2'b00, c2_d_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c2_d_q <= 1'b0;
      off_q  <= '0;
      code_q <= MOD_N;
    end else begin
      c2_d_q <= c2_i;
      off_q  <= off_d;
      code_q <= off_to_code(off_d);
    end
  end

  assign offset_o = off_q;
  assign code_o   = code_q;

  logic past_vld_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_vld_q <= 1'b0;
    else         past_vld_q <= 1'b1;
  end

  // R1
  code_m1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_q == -3'sd1) |-> (code_q == MOD_M1));
  // R1
  code_p2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_q == 3'sd2) |-> (code_q == MOD_P2));
  // R2
  off_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_q >= -3'sd1) && (off_q != 3'sd3));
  // R2
  carry_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld_q |-> (c2_d_q == $past(c2_i)));
endmodule

// File: rtl/mash11_mod_seq.sv
module mash11_mod_seq #(
  parameter int FRAC_W = 7,
  parameter int SEED_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              dith_en_i,
  input  logic [SEED_W-1:0] seed_i,
  output logic [1:0]        mod_code_o,
  output logic signed [2:0] offset_o
);
  localparam int NSTG = 2;

  logic              dith_bit;
  logic [FRAC_W-1:0] stg_in  [NSTG];
  logic              stg_cin [NSTG];
  logic              stg_c   [NSTG];
  logic [FRAC_W-1:0] stg_res [NSTG];

  mash_dither_lfsr #(.LFSR_W(SEED_W)) u_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .seed_i(seed_i),
    .en_i  (dith_en_i),
    .bit_o (dith_bit)
  );

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    if (s == 0) begin : g_head
      assign stg_in[s]  = frac_i;
      assign stg_cin[s] = dith_bit;
    end else begin : g_tail
      assign stg_in[s]  = stg_res[s-1];
      assign stg_cin[s] = 1'b0;
    end
    mash_acc_stage #(.W(FRAC_W)) u_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .in_i   (stg_in[s]),
      .cin_i  (stg_cin[s]),
      .carry_o(stg_c[s]),
      .res_o  (stg_res[s])
    );
  end

  mash_out_comb u_comb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .c1_i    (stg_c[0]),
    .c2_i    (stg_c[NSTG-1]),
    .offset_o(offset_o),
    .code_o  (mod_code_o)
  );
endmodule

// File: tb/mash11_mod_seq_tb.sv
module mash11_mod_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FW  = 7;
  localparam int MOD = 1 << FW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [FW-1:0] frac = '0;
  logic          den = 1'b0;
  logic [15:0]   seed = 16'h0000;
  logic [1:0]    code;
  logic signed [2:0] off;

  int checks = 0;
  int fails  = 0;

  int m_acc1, m_acc2, m_c2d, m_lfsr, m_seeded, m_off;

  always #(CLK_PERIOD/2) clk = ~clk;

  mash11_mod_seq #(.FRAC_W(FW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frac_i(frac), .dith_en_i(den),
    .seed_i(seed), .mod_code_o(code), .offset_o(off)
  );

  function automatic int exp_code(int o);
    if (o == -1) return 3;
    if (o == 1)  return 1;
    if (o == 2)  return 2;
    return 0;
  endfunction

  task automatic model_reset();
    m_acc1 = 0; m_acc2 = 0; m_c2d = 0; m_lfsr = 0; m_seeded = 0; m_off = 0;
  endtask

  task automatic model_step(int f, int d_en, int sd);
    int d, s1, s2, c1, c2, fb;
    d  = (m_seeded != 0 && d_en != 0) ? (m_lfsr & 1) : 0;
    s1 = m_acc1 + f + d;
    c1 = (s1 >= MOD) ? 1 : 0;
    m_acc1 = s1 % MOD;
    s2 = m_acc2 + m_acc1;
    c2 = (s2 >= MOD) ? 1 : 0;
    m_acc2 = s2 % MOD;
    m_off = c1 + c2 - m_c2d;
    m_c2d = c2;
    if (m_seeded == 0) m_lfsr = (sd == 0) ? 1 : sd;
    else begin
      fb = ((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1;
      m_lfsr = ((m_lfsr << 1) | fb) & 16'hFFFF;
    end
    m_seeded = 1;
  endtask

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // one clock: inputs already stable, edge, model update, compare at negedge
  task automatic cycle(string req);
    @(posedge clk);
    model_step(int'(frac), int'(den), int'(seed));
    @(negedge clk);
    check(int'(off) == m_off, {req, "/R2 offset"}, int'(off), m_off);
    check(int'(code) == exp_code(m_off), {req, "/R1 code"}, int'(code), exp_code(m_off));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    // R6
    check(int'(off) == 0, "R6 offset in reset", int'(off), 0);
    check(code == 2'b00, "R6 code in reset", int'(code), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int sum;
    // R5: zero word, no dither
    frac = '0; den = 1'b0; seed = 16'hACE1;
    do_reset();
    for (int i = 0; i < 40; i++) begin
      cycle("R5");
      check(code == 2'b00, "R5 steady code", int'(code), 0);
    end

    // R4: mean for 2/8 and 5/8 of full scale
    for (int k = 0; k < 2; k++) begin
      int fv;
      fv = (k == 0) ? (MOD * 2 / 8) : (MOD * 5 / 8);
      frac = FW'(fv);
      do_reset();
      sum = 0;
      for (int i = 0; i < 1024; i++) begin
        cycle("R4");
        sum += int'(off);
      end
      check((sum * MOD - fv * 1024) <= MOD && (fv * 1024 - sum * MOD) <= MOD,
            "R4 mean", sum, fv * 1024 / MOD);
    end

    // R3: extreme words
    frac = FW'(MOD - 1);
    do_reset();
    for (int i = 0; i < 300; i++) cycle("R3 max");
    frac = FW'(1);
    for (int i = 0; i < 300; i++) cycle("R3 min");

    // R7: dither on with a seed, then zero seed fallback
    den = 1'b1; seed = 16'hACE1; frac = FW'(MOD / 4);
    do_reset();
    for (int i = 0; i < 500; i++) cycle("R7 dither");
    den = 1'b0;
    for (int i = 0; i < 100; i++) cycle("R7 dither off");
    den = 1'b1; seed = 16'h0000; frac = '0;
    do_reset();
    for (int i = 0; i < 300; i++) cycle("R7 zero seed");

    // changing word every cycle
    den = 1'b0;
    do_reset();
    for (int i = 0; i < 400; i++) begin
      frac = FW'((i * 37 + 11) % MOD);
      den  = ((i / 50) % 2) == 1;
      cycle("R3 varying");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule